// File: doc/BRIEF.md
# Four-Port Bidirectional GPIO Bank with Reset-Aware Retention

This block holds four 4-bit bidirectional ports for a small 4-bit controller. Each port has an output latch, a direction register and per-pin output-enable lines that go to the tri-state pads. Software reaches the ports through a 2-bit port address, a register-kind select, 4-bit write data, a write strobe and a combinational 4-bit read bus. A pin set as an output drives its latch bit. A pin set as an input leaves its driver off. A read of that input pin returns the pad level after a two-flop synchroniser.

Three events return every pin to input mode, and each one treats the stored state differently. The asynchronous power-on reset leaves the latch uninitialised. A chip-enable reset and a clock-stop request both keep the latch. While the clock is stopped, the input buffers of ports 0 to 2 are held off, so a floating pad cannot toggle them. Port 3 changes direction only as a whole nibble, and its input path is never gated. In halt, every write is ignored and all state holds.

Top module: `gpio_bank`

## Requirements
- R1: While rst_ni is low, and directly after it, all pad_oe_o bits are 0. The synchroniser flops and the input gate are cleared.
- R2: A write with sel_dir_i=1 to port 0, 1 or 2 loads that port's direction register bit by bit from wdata_i. A direction bit of 1 means output, and its pad_oe_o bit is 1.
- R3: A write with sel_dir_i=1 to port 3 sets all four of its pins to the value of wdata_i[0]. pad_oe_o[15:12] is always 4'h0 or 4'hF.
- R4: A write with sel_dir_i=0 loads the addressed latch whether its pins are inputs or outputs. A pin later switched to output drives the stored value.
- R5: For an output pin, pad_out_o carries the latch bit, and a read returns the latch bit rather than the pad level.
- R6: For an input pin, a read returns the pad level sampled through two flops. A pad change shows on rdata_o after the second rising edge.
- R7: Chip-enable reset (ce_rst_i=1 at an edge) clears all direction bits, keeps every latch and ignores a write in that cycle.
- R8: Clock stop (clk_stop_i=1 at an edge) clears all direction bits, keeps every latch and ignores a write in that cycle.
- R9: After each edge that samples clk_stop_i=1, reads of input pins on ports 0 to 2 return 0. This lasts until the first edge that samples clk_stop_i=0. Port 3 reads stay live.
- R10: While halt_i=1, with no chip-enable reset or clock stop, writes are ignored and direction and latch contents hold.
- R11: When ce_rst_i and clk_stop_i are both 1 at an edge, the chip-enable reset wins and no input gating follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ce_rst_i | input | 1 | Synchronous chip-enable reset |
| clk_stop_i | input | 1 | Clock-stop request level |
| halt_i | input | 1 | Halt state, blocks writes |
| addr_i | input | 2 | Port select |
| sel_dir_i | input | 1 | Write target: 1 direction register, 0 latch |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data of the selected port |
| pad_in_i | input | 16 | Pad levels, port p on bits 4p+3:4p |
| pad_out_o | output | 16 | Pad drive values |
| pad_oe_o | output | 16 | Pad output enables |

## Verification
The hardest condition to reach is the one-cycle window after clock stop is released. In that window, gating is still active while the pads and the synchronisers already carry new levels. The stimulus drives pads high on all ports during a multi-cycle stop. It then drops clk_stop_i and reads port 0 and port 3 across the release edges. A second case raises the stop request in the same cycle as a chip-enable reset, to show that no gate window opens. A randomised phase then mixes sparse resets, stops and halts with writes and pad noise, and a behavioural model is compared against the outputs after every edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NPORT    = 4;
  localparam int unsigned PW       = 4;
  localparam int unsigned AW       = $clog2(NPORT);
  localparam int unsigned NPIN     = NPORT * PW;
  localparam int unsigned NIB_PORT = NPORT - 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned W       = 4,
  parameter bit          NIB_DIR = 1'b0,
  parameter bit          GATED   = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_lat_i,
  input  logic         wr_dir_i,
  input  logic         force_in_i,
  input  logic         gate_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] lat_q;
  logic [W-1:0] in_eff;

  // latch has no reset: undefined after power-on
  always_ff @(posedge clk_i) begin
    if (wr_lat_i) lat_q <= wdata_i;
  end

  generate
    if (NIB_DIR) begin : g_nib
      logic dir_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         dir_q <= 1'b0;
        else if (force_in_i) dir_q <= 1'b0;
        else if (wr_dir_i)   dir_q <= wdata_i[0];
      end
      assign oe_o = {W{dir_q}};
    end else begin : g_bit
      logic [W-1:0] dir_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         dir_q <= '0;
        else if (force_in_i) dir_q <= '0;
        else if (wr_dir_i)   dir_q <= wdata_i;
      end
      assign oe_o = dir_q;
    end

    if (GATED) begin : g_gate
      assign in_eff = gate_i ? '0 : pin_i;
    end else begin : g_nogate
      assign in_eff = pin_i;
    end
  endgenerate

  assign out_o = lat_q;
  assign rd_o  = (oe_o & lat_q) | (~oe_o & in_eff);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_rst_i,
  input  logic            clk_stop_i,
  input  logic            halt_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            sel_dir_i,
  input  logic            we_i,
  input  logic [PW-1:0]   wdata_i,
  output logic [PW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pad_in_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o
);
  logic [NPIN-1:0] pin_sync;
  logic [PW-1:0]   rd_all [NPORT];
  logic            gate_q;
  logic            force_in;
  logic            wr_ok;

  assign force_in = ce_rst_i | clk_stop_i;
  assign wr_ok    = we_i & ~halt_i & ~force_in;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  // chip-enable reset outranks clock stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= clk_stop_i & ~ce_rst_i;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam bit IS_NIB = (p == NIB_PORT);
    logic sel;
    assign sel = (addr_i == AW'(p));
    gpio_port #(.W(PW), .NIB_DIR(IS_NIB), .GATED(!IS_NIB)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_lat_i   (wr_ok & sel & ~sel_dir_i),
      .wr_dir_i   (wr_ok & sel & sel_dir_i),
      .force_in_i (force_in),
      .gate_i     (gate_q),
      .wdata_i    (wdata_i),
      .pin_i      (pin_sync[p*PW +: PW]),
      .out_o      (pad_out_o[p*PW +: PW]),
      .oe_o       (pad_oe_o[p*PW +: PW]),
      .rd_o       (rd_all[p])
    );
  end

  assign rdata_o = rd_all[addr_i];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ce_rst_i,
  input logic            clk_stop_i,
  input logic            halt_i,
  input logic [AW-1:0]   addr_i,
  input logic [PW-1:0]   rdata_o,
  input logic [NPIN-1:0] pad_out_o,
  input logic [NPIN-1:0] pad_oe_o,
  input logic            gate_q
);
  // R7
  ce_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_rst_i |=> pad_oe_o == '0);
  // R8
  stop_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stop_i |=> pad_oe_o == '0);
  // R3
  nib_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[NPIN-1 -: PW] == '0 || pad_oe_o[NPIN-1 -: PW] == '1);
  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !ce_rst_i && !clk_stop_i) |=>
      ($stable(pad_oe_o) && $stable(pad_out_o & pad_oe_o)));
  // R9
  gate_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && addr_i != AW'(NIB_PORT)) |-> rdata_o == '0);
  // R11
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_rst_i |=> !gate_q);
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_rst_i   (ce_rst_i),
  .clk_stop_i (clk_stop_i),
  .halt_i     (halt_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .gate_q     (gate_q)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_rst = 1'b0, clk_stop = 1'b0, halt = 1'b0;
  logic [1:0]  addr = '0;
  logic        sel_dir = 1'b0, we = 1'b0;
  logic [3:0]  wdata = '0;
  logic [3:0]  rdata;
  logic [15:0] pad_in = '0, pad_out, pad_oe;

  always #5 clk = ~clk;

  gpio_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_rst_i(ce_rst), .clk_stop_i(clk_stop),
    .halt_i(halt), .addr_i(addr), .sel_dir_i(sel_dir), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // behavioural model
  logic [3:0]  m_lat [4];
  logic [3:0]  m_known [4];
  logic [15:0] m_dir, m_s1, m_s2;
  bit          m_gate;
  int          n_vec = 0, n_err = 0;
  string       cur_req = "R1";
  bit          done = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_s1 = '0; m_s2 = '0; m_gate = 1'b0;
      for (int p = 0; p < 4; p++) m_known[p] = '0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      m_gate = clk_stop && !ce_rst;
      if (ce_rst || clk_stop) m_dir = '0;
      else if (we && !halt) begin
        if (sel_dir) begin
          if (addr == 2'd3) m_dir[15:12] = {4{wdata[0]}};
          else m_dir[addr*4 +: 4] = wdata;
        end else begin
          m_lat[addr] = wdata;
          m_known[addr] = 4'hF;
        end
      end
    end
  end

  task automatic fail_line(string what, logic [15:0] act, logic [15:0] exp);
    n_err++;
    $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e_rd, m_rd;
      logic [15:0] e_out, m_out;
      n_vec++;
      if (pad_oe !== m_dir) fail_line("oe", pad_oe, m_dir);
      e_rd = '0; m_rd = '0;
      for (int b = 0; b < 4; b++) begin
        int i;
        i = addr * 4 + b;
        if (m_dir[i]) begin
          if (m_known[addr][b]) begin m_rd[b] = 1'b1; e_rd[b] = m_lat[addr][b]; end
        end else begin
          m_rd[b] = 1'b1;
          e_rd[b] = (m_gate && addr != 2'd3) ? 1'b0 : m_s2[i];
        end
      end
      if ((rdata & m_rd) !== (e_rd & m_rd)) fail_line("rdata", {12'b0, rdata}, {12'b0, e_rd});
      e_out = '0; m_out = '0;
      for (int i = 0; i < 16; i++) begin
        if (m_dir[i] && m_known[i/4][i%4]) begin
          m_out[i] = 1'b1; e_out[i] = m_lat[i/4][i%4];
        end
      end
      if ((pad_out & m_out) !== (e_out & m_out)) fail_line("pad_out", pad_out, e_out);
    end
  end

  task automatic cyc(bit w, bit sd, logic [1:0] a, logic [3:0] d);
    @(negedge clk); #1;
    we = w; sel_dir = sd; addr = a; wdata = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, addr, 4'h0);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #23;
    n_vec++;
    if (pad_oe !== 16'h0) fail_line("reset oe", pad_oe, 16'h0); // R1
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    cur_req = "R6"; pad_in = 16'hA5C3;
    for (int a = 0; a < 4; a++) begin cyc(0, 0, 2'(a), 0); idle(2); end
    pad_in = 16'h5A3C; idle(1); idle(2);

    cur_req = "R4";
    for (int a = 0; a < 4; a++) cyc(1, 0, 2'(a), 4'(a * 3 + 5));
    cyc(0, 0, 2'd1, 0); idle(2);
    cur_req = "R2"; cyc(1, 1, 2'd0, 4'b1010); cyc(0, 0, 2'd0, 0); idle(2);
    cur_req = "R4"; cyc(1, 1, 2'd1, 4'hF); cyc(0, 0, 2'd1, 0); idle(1);
    cur_req = "R5"; pad_in = ~pad_in; cyc(1, 0, 2'd0, 4'b0110); cyc(0, 0, 2'd0, 0); idle(3);
    cur_req = "R3"; cyc(1, 1, 2'd3, 4'b0001); cyc(0, 0, 2'd3, 0); idle(1);
    cyc(1, 1, 2'd3, 4'b1110); idle(2);
    cyc(1, 1, 2'd3, 4'b0011); cyc(1, 0, 2'd3, 4'h9); idle(2);

    cur_req = "R10"; halt = 1'b1;
    cyc(1, 0, 2'd0, 4'h0); cyc(1, 1, 2'd0, 4'h0); cyc(1, 1, 2'd3, 4'h0); idle(2);
    halt = 1'b0; idle(1);

    cur_req = "R7"; cyc(1, 1, 2'd2, 4'hF); idle(1);
    ce_rst = 1'b1; cyc(1, 0, 2'd2, 4'h0); ce_rst = 1'b0;
    cyc(0, 0, 2'd2, 0); idle(2);
    cyc(1, 1, 2'd2, 4'hF); idle(2);

    cur_req = "R8"; cyc(1, 1, 2'd0, 4'hF); cyc(1, 1, 2'd3, 4'h1);
    pad_in = 16'hFFFF; clk_stop = 1'b1;
    cyc(1, 0, 2'd0, 4'h0); cyc(1, 1, 2'd2, 4'hF);
    cur_req = "R9"; cyc(0, 0, 2'd0, 0); cyc(0, 0, 2'd3, 0); cyc(0, 0, 2'd1, 0);
    clk_stop = 1'b0; cyc(0, 0, 2'd0, 0); cyc(0, 0, 2'd0, 0); cyc(0, 0, 2'd3, 0);
    cur_req = "R8"; cyc(1, 1, 2'd0, 4'hF); idle(2);

    cur_req = "R11"; ce_rst = 1'b1; clk_stop = 1'b1;
    cyc(0, 0, 2'd0, 0); ce_rst = 1'b0; clk_stop = 1'b0;
    cyc(0, 0, 2'd1, 0); idle(2);

    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      ce_rst   = (r < 2);
      clk_stop = (r >= 2 && r < 6);
      halt     = (r >= 6 && r < 12);
      if ((k % 7) == 0) pad_in = 16'($urandom);
      cyc(($urandom_range(0, 2) == 0), $urandom_range(0, 1) == 1,
          2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)));
    end
    ce_rst = 1'b0; clk_stop = 1'b0; halt = 1'b0;
    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule